// File: doc/BRIEF.md
# Test Vector Pin Formatter

This block shapes the stimulus and checks the response of a single tester pin. Each vector period it takes a character code and a timing-set index. The character's hardware action comes from a per-set character map. The set also gives two drive edge times, one receive edge time and a return format. Edge times count ticks from the start of the period, and one tick is one clock cycle (1 ns in the intended use).

At drive edge 1 the action forces the pin low or high, repeats the last driven value, or releases the driver. At drive edge 2 the return format can pull a forced pin back to low or high, or invert it. This lets one vector make a complete clock or return-to-zero pulse.

At the receive edge a compare action checks the pin against high, low or high-impedance. It then raises a strobe with a pass/fail flag, and it sets a sticky error bit on a mismatch. A host write port fills the character maps and the timing sets.

The period sequencer is a two-state machine, ST_IDLE and ST_RUN:
- IDLE→RUN happens when `run` is high. The vector is captured and the tick is zeroed.
- RUN→RUN (wrap) happens on the last tick while `run` is high. The next vector is captured and the tick is zeroed.
- RUN→IDLE happens on the last tick while `run` is low.
- IDLE→IDLE happens while `run` is low.

Top module: `vecpin_formatter`

## Requirements
- R1: After reset, pin_drv, pin_oe, cmp_strobe, cmp_fail and err_sticky are 0. Every character map entry holds action 0 (don't-compare). Every edge time holds 31 and every return format is 0.
- R2: In ST_IDLE, a cycle with run=1 captures vec_char/vec_tset and starts a period of PERIOD (16) ticks, numbered 0 to 15. On tick 15 with run=1 the next vector is captured and the following period starts back to back. On tick 15 with run=0 the sequencer returns to ST_IDLE. Vector inputs are ignored outside the capture cycle.
- R3: Host writes use host_we=1. With host_sel=0, host_addr = {tset[8:4], char[3:0]} and host_wdata[2:0] is the action. The action codes are: 0 don't-compare, 1 force low, 2 force high, 3 force previous, 4 release, 5 compare low, 6 compare high, 7 compare Z. With host_sel=1, host_addr[4:0] is the set and host_wdata = {fmt[16:15], rx[14:10], e2[9:5], e1[4:0]}.
- R4: On the tick equal to e1, force low or force high sets pin_oe=1 and pin_drv=0 or 1. The outputs change in the cycle after that tick.
- R5: On the e1 tick, force previous sets pin_oe=1 and keeps pin_drv at its last value. Release sets pin_oe=0 and keeps pin_drv.
- R6: On the e2 tick, and only when the action is force low or force high, the format applies. The formats are: 0 no change, 1 drive 0, 2 drive 1, 3 invert the value left after edge 1. When e1 equals e2, edge 2 is applied last.
- R7: On the rx tick a compare action raises cmp_strobe for one cycle, in the cycle after that tick. cmp_fail is updated in the same cycle to the mismatch result, and it holds between compares:
  - compare high fails unless pin_in=1 and pin_z=0;
  - compare low fails unless pin_in=0 and pin_z=0;
  - compare Z fails unless pin_z=1.
  Don't-compare raises no strobe.
- R8: err_sticky is set in the same cycle as a failing strobe and cleared by any host write.
- R9: An edge time of 16 or more never fires, and the pin and the compare outputs are left unchanged.
- R10: Character code 15 is reserved. Map writes to it are ignored, and it acts as don't-compare with the previous drive.
- R11: Each vector selects its own timing set, so consecutive vectors may use different sets and edge times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per cycle |
| rst_n | input | 1 | Active-low reset |
| run | input | 1 | Request to start or continue periods |
| vec_char | input | 4 | Vector character code |
| vec_tset | input | 5 | Timing set index for the vector |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 1 | 0 selects the character map, 1 selects the timing set |
| host_addr | input | 9 | Host write address |
| host_wdata | input | 17 | Host write data |
| pin_in | input | 1 | Sampled pin logic level |
| pin_z | input | 1 | Pin reads as high-impedance |
| pin_drv | output | 1 | Drive value |
| pin_oe | output | 1 | Driver enable |
| cmp_strobe | output | 1 | Compare result valid pulse |
| cmp_fail | output | 1 | Result of the last compare |
| err_sticky | output | 1 | Accumulated mismatch flag |

## Verification
The assertions check four things on every cycle:
- the tick stays inside the period and is 0 in ST_IDLE;
- a period that ends with run low goes to ST_IDLE;
- the pin outputs change only one cycle after a tick that matched a drive edge, and a release comes from a release action;
- strobes follow a receive-edge tick, a failing strobe always carries the sticky bit, and the sticky bit clears only after a host write.

Only the bench scenarios can show the actual waveforms and compare verdicts of each action. They also show:
- the return formats, and edge 2 winning when it shares a tick with edge 1;
- edges at or beyond the period never firing;
- the reserved character;
- vector inputs being ignored between captures;
- a different timing set taking effect on a back-to-back vector.

// File: rtl/vpf_pkg.sv
package vpf_pkg;
    typedef enum logic [2:0] {
        ACT_NONE = 3'd0,
        ACT_LO   = 3'd1,
        ACT_HI   = 3'd2,
        ACT_PREV = 3'd3,
        ACT_OFF  = 3'd4,
        ACT_CLO  = 3'd5,
        ACT_CHI  = 3'd6,
        ACT_CZ   = 3'd7
    } pin_act_e;

    typedef enum logic [1:0] {
        FMT_NRZ = 2'd0,
        FMT_RZ  = 2'd1,
        FMT_RO  = 2'd2,
        FMT_INV = 2'd3
    } ret_fmt_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/vpf_table.sv
module vpf_table
    import vpf_pkg::*;
#(
    parameter int NUM_TSETS = 32,
    parameter int CODE_W    = 4,
    parameter int TICK_W    = 5,
    localparam int TSET_W    = $clog2(NUM_TSETS),
    localparam int NUM_CHARS = (1 << CODE_W) - 1,
    localparam int ADDR_W    = TSET_W + CODE_W,
    localparam int WORD_W    = 2 + 3 * TICK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic              host_sel,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic [TSET_W-1:0] rd_tset,
    input  logic [CODE_W-1:0] rd_char,
    output pin_act_e          act,
    output logic [TICK_W-1:0] e1_time,
    output logic [TICK_W-1:0] e2_time,
    output logic [TICK_W-1:0] rx_time,
    output ret_fmt_e          fmt
);
    pin_act_e          amap [NUM_TSETS][NUM_CHARS];
    logic [TICK_W-1:0] e1_m [NUM_TSETS];
    logic [TICK_W-1:0] e2_m [NUM_TSETS];
    logic [TICK_W-1:0] rx_m [NUM_TSETS];
    ret_fmt_e          fmt_m [NUM_TSETS];

    logic [TSET_W-1:0] w_tset;
    logic [CODE_W-1:0] w_char;
    logic [TSET_W-1:0] t_tset;

    assign w_tset = host_addr[ADDR_W-1:CODE_W];
    assign w_char = host_addr[CODE_W-1:0];
    assign t_tset = host_addr[TSET_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < NUM_TSETS; t++) begin
                for (int c = 0; c < NUM_CHARS; c++) begin
                    amap[t][c] <= ACT_NONE;
                end
                e1_m[t]  <= '1;
                e2_m[t]  <= '1;
                rx_m[t]  <= '1;
                fmt_m[t] <= FMT_NRZ;
            end
        end else if (host_we) begin
            if (!host_sel) begin
                // reserved top code is never stored (R10)
                if (int'(w_char) < NUM_CHARS) begin
                    amap[w_tset][w_char] <= pin_act_e'(host_wdata[2:0]);
                end
            end else begin
                e1_m[t_tset]  <= host_wdata[TICK_W-1:0];
                e2_m[t_tset]  <= host_wdata[2*TICK_W-1:TICK_W];
                rx_m[t_tset]  <= host_wdata[3*TICK_W-1:2*TICK_W];
                fmt_m[t_tset] <= ret_fmt_e'(host_wdata[WORD_W-1:3*TICK_W]);
            end
        end
    end

    always_comb begin
        if (int'(rd_char) < NUM_CHARS) begin
            act = amap[rd_tset][rd_char];
        end else begin
            act = ACT_NONE;
        end
        e1_time = e1_m[rd_tset];
        e2_time = e2_m[rd_tset];
        rx_time = rx_m[rd_tset];
        fmt     = fmt_m[rd_tset];
    end
endmodule

// File: rtl/vpf_seq.sv
module vpf_seq
    import vpf_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int TSET_W = 5,
    parameter int TICK_W = 5,
    parameter int PERIOD = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] vec_char,
    input  logic [TSET_W-1:0] vec_tset,
    output logic [TICK_W-1:0] tick,
    output logic              running,
    output logic [CODE_W-1:0] cur_char,
    output logic [TSET_W-1:0] cur_tset
);
    localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(PERIOD - 1);

    seq_state_e state, state_nx;
    logic       last;
    logic       capture;

    assign last    = (tick == LAST_TICK);
    assign running = (state == ST_RUN);

    always_comb begin
        state_nx = state;
        capture  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (run) begin
                    state_nx = ST_RUN;
                    capture  = 1'b1;
                end
            end
            ST_RUN: begin
                if (last) begin
                    if (run) begin
                        capture = 1'b1;
                    end else begin
                        state_nx = ST_IDLE;
                    end
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick     <= '0;
            cur_char <= '0;
            cur_tset <= '0;
        end else begin
            if (capture) begin
                cur_char <= vec_char;
                cur_tset <= vec_tset;
                tick     <= '0;
            end else if (state == ST_RUN && !last) begin
                tick <= tick + 1'b1;
            end else begin
                tick <= '0;
            end
        end
    end

    always_comb begin
        assert_tick_range_R2: assert (!rst_n || tick <= LAST_TICK);
    end

    assert_idle_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> tick == '0);

    assert_end_to_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        running && tick == LAST_TICK && !run |=> !running);
endmodule

// File: rtl/vpf_engine.sv
module vpf_engine
    import vpf_pkg::*;
#(
    parameter int TICK_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              running,
    input  logic [TICK_W-1:0] tick,
    input  pin_act_e          act,
    input  logic [TICK_W-1:0] e1_time,
    input  logic [TICK_W-1:0] e2_time,
    input  logic [TICK_W-1:0] rx_time,
    input  ret_fmt_e          fmt,
    input  logic              pin_in,
    input  logic              pin_z,
    input  logic              host_we,
    output logic              pin_drv,
    output logic              pin_oe,
    output logic              cmp_strobe,
    output logic              cmp_fail,
    output logic              err_sticky
);
    logic hit1, hit2, hitr;
    logic drv_nx, oe_nx;
    logic is_cmp, mism;

    assign hit1 = running && (tick == e1_time);
    assign hit2 = running && (tick == e2_time);
    assign hitr = running && (tick == rx_time);

    always_comb begin
        drv_nx = pin_drv;
        oe_nx  = pin_oe;
        if (hit1) begin
            case (act)
                ACT_LO:   begin oe_nx = 1'b1; drv_nx = 1'b0; end
                ACT_HI:   begin oe_nx = 1'b1; drv_nx = 1'b1; end
                ACT_PREV: begin oe_nx = 1'b1; end
                ACT_OFF:  begin oe_nx = 1'b0; end
                default:  begin end
            endcase
        end
        if (hit2 && (act == ACT_LO || act == ACT_HI)) begin
            case (fmt)
                FMT_RZ:  begin oe_nx = 1'b1; drv_nx = 1'b0; end
                FMT_RO:  begin oe_nx = 1'b1; drv_nx = 1'b1; end
                FMT_INV: begin oe_nx = 1'b1; drv_nx = ~drv_nx; end
                default: begin end
            endcase
        end
    end

    always_comb begin
        is_cmp = 1'b0;
        mism   = 1'b0;
        case (act)
            ACT_CHI: begin is_cmp = 1'b1; mism = pin_z || !pin_in; end
            ACT_CLO: begin is_cmp = 1'b1; mism = pin_z || pin_in;  end
            ACT_CZ:  begin is_cmp = 1'b1; mism = !pin_z;           end
            default: begin end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_drv    <= 1'b0;
            pin_oe     <= 1'b0;
            cmp_strobe <= 1'b0;
            cmp_fail   <= 1'b0;
            err_sticky <= 1'b0;
        end else begin
            pin_drv    <= drv_nx;
            pin_oe     <= oe_nx;
            cmp_strobe <= hitr && is_cmp;
            if (hitr && is_cmp) begin
                cmp_fail <= mism;
            end
            if (host_we) begin
                err_sticky <= 1'b0;
            end
            if (hitr && is_cmp && mism) begin
                err_sticky <= 1'b1;
            end
        end
    end

    assert_drive_on_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({pin_drv, pin_oe}) |-> $past(running && (tick == e1_time || tick == e2_time)));

    assert_release_from_act_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pin_oe) |-> $past(act == ACT_OFF));

    assert_strobe_on_rx_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_strobe |-> $past(running && tick == rx_time));

    assert_sticky_follows_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_strobe && cmp_fail |-> err_sticky);

    assert_sticky_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_sticky) |-> $past(host_we));
endmodule

// File: rtl/vecpin_formatter.sv
module vecpin_formatter
    import vpf_pkg::*;
#(
    parameter int NUM_TSETS = 32,
    parameter int CODE_W    = 4,
    parameter int TICK_W    = 5,
    parameter int PERIOD    = 16,
    localparam int TSET_W   = $clog2(NUM_TSETS),
    localparam int ADDR_W   = TSET_W + CODE_W,
    localparam int WORD_W   = 2 + 3 * TICK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] vec_char,
    input  logic [TSET_W-1:0] vec_tset,
    input  logic              host_we,
    input  logic              host_sel,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic              pin_in,
    input  logic              pin_z,
    output logic              pin_drv,
    output logic              pin_oe,
    output logic              cmp_strobe,
    output logic              cmp_fail,
    output logic              err_sticky
);
    logic [TICK_W-1:0] tick;
    logic              running;
    logic [CODE_W-1:0] cur_char;
    logic [TSET_W-1:0] cur_tset;
    pin_act_e          act;
    logic [TICK_W-1:0] e1_time, e2_time, rx_time;
    ret_fmt_e          fmt;

    vpf_seq #(
        .CODE_W (CODE_W),
        .TSET_W (TSET_W),
        .TICK_W (TICK_W),
        .PERIOD (PERIOD)
    ) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .vec_char (vec_char),
        .vec_tset (vec_tset),
        .tick     (tick),
        .running  (running),
        .cur_char (cur_char),
        .cur_tset (cur_tset)
    );

    vpf_table #(
        .NUM_TSETS (NUM_TSETS),
        .CODE_W    (CODE_W),
        .TICK_W    (TICK_W)
    ) i_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_sel   (host_sel),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .rd_tset    (cur_tset),
        .rd_char    (cur_char),
        .act        (act),
        .e1_time    (e1_time),
        .e2_time    (e2_time),
        .rx_time    (rx_time),
        .fmt        (fmt)
    );

    vpf_engine #(
        .TICK_W (TICK_W)
    ) i_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .running    (running),
        .tick       (tick),
        .act        (act),
        .e1_time    (e1_time),
        .e2_time    (e2_time),
        .rx_time    (rx_time),
        .fmt        (fmt),
        .pin_in     (pin_in),
        .pin_z      (pin_z),
        .host_we    (host_we),
        .pin_drv    (pin_drv),
        .pin_oe     (pin_oe),
        .cmp_strobe (cmp_strobe),
        .cmp_fail   (cmp_fail),
        .err_sticky (err_sticky)
    );
endmodule

// File: tb/test_vecpin_formatter.sv
module test_vecpin_formatter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [3:0]  vec_char = '0;
    logic [4:0]  vec_tset = '0;
    logic        host_we = 1'b0;
    logic        host_sel = 1'b0;
    logic [8:0]  host_addr = '0;
    logic [16:0] host_wdata = '0;
    logic        pin_in = 1'b0;
    logic        pin_z = 1'b0;
    logic        pin_drv, pin_oe, cmp_strobe, cmp_fail, err_sticky;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench copy of what it wrote, plus expected pin state
    logic [2:0] b_act [32][16];
    logic [4:0] b_e1 [32];
    logic [4:0] b_e2 [32];
    logic [4:0] b_rx [32];
    logic [1:0] b_fmt [32];
    logic m_drv = 0, m_oe = 0, m_fail = 0, m_sticky = 0;
    logic [3:0] cur_c;
    logic [4:0] cur_t;

    always #4 clk = ~clk;

    vecpin_formatter i_vecpin_formatter (
        .clk(clk), .rst_n(rst_n), .run(run), .vec_char(vec_char), .vec_tset(vec_tset),
        .host_we(host_we), .host_sel(host_sel), .host_addr(host_addr), .host_wdata(host_wdata),
        .pin_in(pin_in), .pin_z(pin_z), .pin_drv(pin_drv), .pin_oe(pin_oe),
        .cmp_strobe(cmp_strobe), .cmp_fail(cmp_fail), .err_sticky(err_sticky)
    );

    task automatic check(input bit ok, input string req, input logic [4:0] act_v, input logic [4:0] exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act_v, exp_v);
        end
    endtask

    task automatic wr_map(input int t, input int c, input logic [2:0] a);
        @(negedge clk);
        host_we = 1; host_sel = 0;
        host_addr = {5'(t), 4'(c)};
        host_wdata = {14'd0, a};
        @(negedge clk);
        host_we = 0;
        if (c != 15) b_act[t][c] = a;
        m_sticky = 0;
    endtask

    task automatic wr_time(input int t, input int e1, input int e2, input int rx, input int f);
        @(negedge clk);
        host_we = 1; host_sel = 1;
        host_addr = 9'(t);
        host_wdata = {2'(f), 5'(rx), 5'(e2), 5'(e1)};
        @(negedge clk);
        host_we = 0;
        b_e1[t] = 5'(e1); b_e2[t] = 5'(e2); b_rx[t] = 5'(rx); b_fmt[t] = 2'(f);
        m_sticky = 0;
    endtask

    task automatic start_vec(input int c, input int t, input logic pin_v, input logic z_v);
        @(negedge clk);
        vec_char = 4'(c); vec_tset = 5'(t); run = 1;
        pin_in = pin_v; pin_z = z_v;
        cur_c = 4'(c); cur_t = 5'(t);
        @(negedge clk);
        run = 0;
        vec_char = 4'(~c); vec_tset = 5'(~t);   // ignored between captures (R2)
    endtask

    // checks 16 samples of the period; with chain, hands the next vector over at the end
    task automatic period(input string req, input bit chain, input int nc, input int nt);
        logic [2:0] a;
        logic st, mm, cmp;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            a = b_act[cur_t][cur_c];
            if (5'(i) == b_e1[cur_t]) begin
                case (a)
                    3'd1: begin m_oe = 1; m_drv = 0; end
                    3'd2: begin m_oe = 1; m_drv = 1; end
                    3'd3: m_oe = 1;
                    3'd4: m_oe = 0;
                    default: ;
                endcase
            end
            if (5'(i) == b_e2[cur_t] && (a == 3'd1 || a == 3'd2)) begin
                case (b_fmt[cur_t])
                    2'd1: begin m_oe = 1; m_drv = 0; end
                    2'd2: begin m_oe = 1; m_drv = 1; end
                    2'd3: begin m_oe = 1; m_drv = ~m_drv; end
                    default: ;
                endcase
            end
            cmp = (a >= 3'd5);
            mm = (a == 3'd6) ? (pin_z || !pin_in) :
                 (a == 3'd5) ? (pin_z || pin_in) : !pin_z;
            st = cmp && (5'(i) == b_rx[cur_t]);
            if (st) begin
                m_fail = mm;
                if (mm) m_sticky = 1;
            end
            check({pin_drv, pin_oe, cmp_strobe, cmp_fail, err_sticky} ==
                  {m_drv, m_oe, st, m_fail, m_sticky}, req,
                  {pin_drv, pin_oe, cmp_strobe, cmp_fail, err_sticky},
                  {m_drv, m_oe, st, m_fail, m_sticky});
            if (chain && i == 14) begin
                vec_char = 4'(nc); vec_tset = 5'(nt); run = 1;
            end
            if (chain && i == 15) begin
                run = 0; vec_char = 4'(~nc); vec_tset = 5'(~nt);
                cur_c = 4'(nc); cur_t = 5'(nt);
            end
        end
    endtask

    task automatic t_reset;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check({pin_drv, pin_oe, cmp_strobe, cmp_fail, err_sticky} == 5'd0, "R1 reset outputs",
              {pin_drv, pin_oe, cmp_strobe, cmp_fail, err_sticky}, 5'd0);
        start_vec(6, 0, 0, 0);
        period("R1 default tables inert", 0, 0, 0);
    endtask

    task automatic t_nrz;
        wr_time(0, 2, 31, 31, 0);
        wr_map(0, 1, 3'd2); wr_map(0, 2, 3'd1); wr_map(0, 3, 3'd3); wr_map(0, 4, 3'd4);
        start_vec(1, 0, 0, 0); period("R4 R3 force high", 0, 0, 0);
        start_vec(2, 0, 0, 0); period("R4 force low", 0, 0, 0);
    endtask

    task automatic t_prev_release;
        start_vec(1, 0, 0, 0); period("R4 force high again", 0, 0, 0);
        start_vec(4, 0, 0, 0); period("R5 release keeps value", 0, 0, 0);
        check(pin_drv == 1 && pin_oe == 0, "R5 released high", {3'd0, pin_drv, pin_oe}, 5'b00010);
        start_vec(3, 0, 0, 0); period("R5 force previous", 0, 0, 0);
        check(pin_drv == 1 && pin_oe == 1, "R5 previous high", {3'd0, pin_drv, pin_oe}, 5'b00011);
    endtask

    task automatic t_formats;
        wr_time(1, 3, 9, 31, 1); wr_map(1, 1, 3'd2);
        start_vec(1, 1, 0, 0); period("R6 return to zero pulse", 0, 0, 0);
        wr_time(2, 4, 10, 31, 2); wr_map(2, 2, 3'd1);
        start_vec(2, 2, 0, 0); period("R6 return to one", 0, 0, 0);
        wr_time(3, 5, 5, 31, 3); wr_map(3, 1, 3'd2);
        start_vec(1, 3, 0, 0); period("R6 invert, edge 2 last", 0, 0, 0);
        check(pin_drv == 0, "R6 same tick result", {4'd0, pin_drv}, 5'd0);
    endtask

    task automatic t_compare;
        wr_time(4, 31, 31, 7, 0);
        wr_map(4, 5, 3'd5); wr_map(4, 6, 3'd6); wr_map(4, 7, 3'd7);
        start_vec(6, 4, 1, 0); period("R7 compare high pass", 0, 0, 0);
        start_vec(5, 4, 1, 0); period("R7 R8 compare low fail", 0, 0, 0);
        start_vec(7, 4, 0, 1); period("R7 compare Z pass", 0, 0, 0);
        start_vec(6, 4, 1, 1); period("R7 compare high on Z fails", 0, 0, 0);
        start_vec(0, 4, 0, 0); period("R7 dont compare holds flag", 0, 0, 0);
    endtask

    task automatic t_sticky_clear;
        check(err_sticky == 1, "R8 sticky set", {4'd0, err_sticky}, 5'd1);
        wr_map(4, 8, 3'd6);
        check(err_sticky == 0, "R8 sticky cleared by write", {4'd0, err_sticky}, 5'd0);
    endtask

    task automatic t_late_edges;
        wr_time(5, 16, 20, 16, 1);
        wr_map(5, 2, 3'd1); wr_map(5, 6, 3'd6);
        start_vec(2, 5, 0, 0); period("R9 late drive edge", 0, 0, 0);
        start_vec(6, 5, 0, 0); period("R9 late receive edge", 0, 0, 0);
    endtask

    task automatic t_reserved;
        wr_time(6, 1, 31, 2, 0);
        wr_map(6, 15, 3'd1);
        wr_map(6, 14, 3'd5);
        start_vec(15, 6, 1, 0); period("R10 reserved char inert", 0, 0, 0);
        start_vec(14, 6, 1, 0); period("R10 neighbour char works", 0, 0, 0);
    endtask

    task automatic t_switch;
        start_vec(2, 0, 0, 0);
        period("R11 set 0 then chain", 1, 1, 1);
        period("R11 R2 back to back set 1", 1, 2, 2);
        period("R11 R2 back to back set 2", 0, 0, 0);
    endtask

    initial begin
        for (int t = 0; t < 32; t++) begin
            for (int c = 0; c < 16; c++) b_act[t][c] = 3'd0;
            b_e1[t] = 5'd31; b_e2[t] = 5'd31; b_rx[t] = 5'd31; b_fmt[t] = 2'd0;
        end
        t_reset();
        t_nrz();
        t_prev_release();
        t_formats();
        t_compare();
        t_sticky_clear();
        t_late_edges();
        t_reserved();
        t_switch();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule